// File: doc/BRIEF.md
# Fan Tachometer Period Capture Channel

This block measures the period of one fan tachometer signal. A 16-bit counter starts each measurement at 0xFFFF and steps down by one on every tick of a prescaled time base. When the selected tachometer edge arrives, the current count is copied into a capture register and a capture strobe fires. A slow or stalled fan lets the counter run past zero, which ends the measurement with an underflow strobe. A programmable compare test can also end a measurement early. It has three tests: an immediate stop, a stop when the count reaches a target, and a stop when the count falls below it. The tests are ranked by priority. Each of these early stops raises a compare-hit strobe and does not change the capture register.

Two fan inputs share the channel and a select bit picks one of them. The chosen input passes through a two-flop synchronizer, and an edge-select bit decides whether rising or falling transitions count. The channel does nothing unless both the mode-5 enable and the channel enable are high. Configuration arrives on plain control pins and results leave on plain status pins. The block has no valid/ready stream interface, because each result is a single-cycle strobe with a stable register behind it that the consumer may sample at any time. No back-pressure exists. A consumer that misses a strobe can still read the last captured value.

Top module: `tach_capture_channel`

## Requirements
- R1: After reset, count_o is 0xFFFF, capture_o is 0x0000 and all three strobes are low.
- R2: While the channel is active and clk_en_i is 1, a tick occurs once every prescale_i+1 system cycles, and each tick lowers count_o by one. With clk_en_i at 0 no tick occurs and count_o holds its value.
- R3: Unless mode5_en_i and chan_en_i are both 1, count_o is held at 0xFFFF and no strobe fires. Edges and ticks are ignored, and capture_o keeps its value.
- R4: tach_sel_i=0 selects tach_pri_i and tach_sel_i=1 selects tach_alt_i. Transitions on the deselected input have no effect.
- R5: edge_sel_i=0 counts rising edges and edge_sel_i=1 counts falling edges. If the selected input changes before clock edge k, the resulting strobe is high in the cycle after clock edge k+2.
- R6: A counted edge copies the current count_o into capture_o and pulses cap_evt_o. count_o returns to 0xFFFF in the same cycle.
- R7: A tick while count_o is 0 pulses udf_evt_o and reloads 0xFFFF, unless compare-config bit 3 is set. capture_o is not changed.
- R8: Compare-config bit 3 (value 0x8) makes every tick a compare hit, with count_o left at 0xFFFF.
- R9: Compare-config bit 2 (value 0x4) makes a tick a hit when count_o-1 is at most cmp_val_i. count_o then shows cmp_val_i for the hit cycle.
- R10: Compare-config bit 1 (value 0x2) makes a tick a hit when cmp_val_i is nonzero and count_o-1 is below cmp_val_i. count_o then shows cmp_val_i-1. With cmp_val_i at 0 this bit has no effect.
- R11: In one cycle a counted edge wins over a tick. Among the tick outcomes the order is bit 3, then underflow, then bit 2, then bit 1.
- R12: A compare hit pulses hit_evt_o and leaves capture_o unchanged. The next cycle is a restart cycle: count_o reloads to 0xFFFF, and any edge or tick in that cycle is dropped.
- R13: Compare-config bit 0 (value 0x1) is accepted but changes nothing.
- R14: Each strobe lasts one cycle, and at most one of the three strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tach_pri_i | input | 1 | Primary fan tachometer input |
| tach_alt_i | input | 1 | Alternate fan tachometer input |
| tach_sel_i | input | 1 | 0 selects the primary input, 1 the alternate |
| edge_sel_i | input | 1 | 0 counts rising edges, 1 falling edges |
| chan_en_i | input | 1 | Channel enable |
| mode5_en_i | input | 1 | Capture-mode enable |
| clk_en_i | input | 1 | Time-base enable |
| prescale_i | input | 8 | Tick divider minus one |
| cmp_val_i | input | 16 | Compare target |
| cmp_cfg_i | input | 4 | Compare config: bit 3 immediate, bit 2 equal, bit 1 below, bit 0 unused select |
| count_o | output | 16 | Live down-count |
| capture_o | output | 16 | Last captured count |
| cap_evt_o | output | 1 | Capture strobe |
| hit_evt_o | output | 1 | Compare-hit strobe |
| udf_evt_o | output | 1 | Underflow strobe |

## Verification
The hardest case to reach from the ports is an edge that lands in the restart cycle after a compare hit. That edge must be dropped rather than captured. To reach it, the stimulus sets a near-0xFFFF equal target so that a hit comes within a few ticks, and it toggles the tachometer at a short period that is not a multiple of the hit interval. Edges then sweep across the restart slot over the run, and a behavioural model judges each cycle. Underflow needs a full 65536-tick run with no edge, so it runs last with prescale 0.

// File: rtl/tach_pkg.sv
package tach_pkg;
  localparam int CFG_W      = 4;
  localparam int CFG_HIGH   = 3;
  localparam int CFG_EQUAL  = 2;
  localparam int CFG_BELOW  = 1;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_CAP  = 2'd1,
    EV_HIT  = 2'd2,
    EV_UDF  = 2'd3
  } tach_evt_e;
endpackage

// File: rtl/tach_edge_sync.sv
module tach_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic fall_i,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;
  logic              level;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= raw_i;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], raw_i};
    end
  endgenerate

  assign level = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= level;

  assign edge_o = fall_i ? (last_q & ~level) : (level & ~last_q);

  p_edge_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_o && $stable(fall_i)) |=> !edge_o);
endmodule

// File: rtl/tach_tick_gen.sv
module tach_tick_gen #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             clk_en_i,
  input  logic [PRE_W-1:0] prescale_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] div_q;
  logic             at_end;

  assign at_end = (div_q == prescale_i);
  assign tick_o = active_i & clk_en_i & at_end;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         div_q <= '0;
    else if (!active_i) div_q <= '0;
    else if (clk_en_i)  div_q <= at_end ? '0 : div_q + 1'b1;

  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && prescale_i != '0 && $stable(prescale_i)) |=> !tick_o);
endmodule

// File: rtl/tach_measure_core.sv
module tach_measure_core
  import tach_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             tick_i,
  input  logic             edge_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  input  logic [CFG_W-1:0] cmp_cfg_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] capture_o,
  output logic             cap_evt_o,
  output logic             hit_evt_o,
  output logic             udf_evt_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d, cap_q, cap_d, dec;
  logic             restart_q, restart_d;
  tach_evt_e        evt_d;
  logic             cap_q_evt, hit_q_evt, udf_q_evt;

  assign dec = cnt_q - 1'b1;

  always_comb begin
    cnt_d     = cnt_q;
    cap_d     = cap_q;
    restart_d = 1'b0;
    evt_d     = EV_NONE;
    if (!active_i || restart_q) begin
      cnt_d = TOP;
    end else if (edge_i) begin
      cap_d = cnt_q;
      cnt_d = TOP;
      evt_d = EV_CAP;
    end else if (tick_i) begin
      if (cmp_cfg_i[CFG_HIGH]) begin
        cnt_d = TOP;  evt_d = EV_HIT;  restart_d = 1'b1;
      end else if (cnt_q == '0) begin
        cnt_d = TOP;  evt_d = EV_UDF;
      end else if (cmp_cfg_i[CFG_EQUAL] && dec <= cmp_val_i) begin
        cnt_d = cmp_val_i;  evt_d = EV_HIT;  restart_d = 1'b1;
      end else if (cmp_cfg_i[CFG_BELOW] && cmp_val_i != '0 && dec < cmp_val_i) begin
        cnt_d = cmp_val_i - 1'b1;  evt_d = EV_HIT;  restart_d = 1'b1;
      end else begin
        cnt_d = dec;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q     <= TOP;
      cap_q     <= '0;
      restart_q <= 1'b0;
      cap_q_evt <= 1'b0;
      hit_q_evt <= 1'b0;
      udf_q_evt <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      cap_q     <= cap_d;
      restart_q <= restart_d;
      cap_q_evt <= (evt_d == EV_CAP);
      hit_q_evt <= (evt_d == EV_HIT);
      udf_q_evt <= (evt_d == EV_UDF);
    end

  assign count_o   = cnt_q;
  assign capture_o = cap_q;
  assign cap_evt_o = cap_q_evt;
  assign hit_evt_o = hit_q_evt;
  assign udf_evt_o = udf_q_evt;

  p_inactive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> (cnt_q == TOP && !cap_q_evt && !hit_q_evt && !udf_q_evt));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !tick_i && !edge_i && !restart_q) |=> $stable(cnt_q));
  p_cap_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_q_evt |-> cnt_q == TOP);
  p_hit_keeps_cap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q_evt || udf_q_evt) |-> cap_q == $past(cap_q));
  p_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q_evt |=> (cnt_q == TOP && !cap_q_evt && !hit_q_evt && !udf_q_evt));
  p_single_strobe_r14: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cap_q_evt, hit_q_evt, udf_q_evt}));
endmodule

// File: rtl/tach_capture_channel.sv
module tach_capture_channel
  import tach_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tach_pri_i,
  input  logic             tach_alt_i,
  input  logic             tach_sel_i,
  input  logic             edge_sel_i,
  input  logic             chan_en_i,
  input  logic             mode5_en_i,
  input  logic             clk_en_i,
  input  logic [PRE_W-1:0] prescale_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  input  logic [CFG_W-1:0] cmp_cfg_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] capture_o,
  output logic             cap_evt_o,
  output logic             hit_evt_o,
  output logic             udf_evt_o
);
  logic active, tick, tach_edge, tach_raw;

  assign active   = mode5_en_i & chan_en_i;
  assign tach_raw = tach_sel_i ? tach_alt_i : tach_pri_i;

  tach_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(tach_raw), .fall_i(edge_sel_i),
    .edge_o(tach_edge)
  );

  tach_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .active_i(active), .clk_en_i(clk_en_i),
    .prescale_i(prescale_i), .tick_o(tick)
  );

  tach_measure_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .active_i(active), .tick_i(tick),
    .edge_i(tach_edge), .cmp_val_i(cmp_val_i), .cmp_cfg_i(cmp_cfg_i),
    .count_o(count_o), .capture_o(capture_o), .cap_evt_o(cap_evt_o),
    .hit_evt_o(hit_evt_o), .udf_evt_o(udf_evt_o)
  );
endmodule

// File: tb/tach_capture_channel_test.sv
`timescale 1ns/100ps
module tach_capture_channel_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tach_pri = 1'b0, tach_alt = 1'b0, tach_sel = 1'b0, edge_sel = 1'b0;
  logic chan_en = 1'b0, mode5_en = 1'b0, clk_en = 1'b0;
  logic [7:0]  prescale = 8'd0;
  logic [15:0] cmp_val = 16'd0;
  logic [3:0]  cmp_cfg = 4'd0;
  logic [15:0] count_o, capture_o;
  logic cap_evt, hit_evt, udf_evt;

  int n_checks = 0, n_fail = 0;
  int n_cap = 0, n_hit = 0, n_udf = 0;
  string cur_tag = "R1";

  // behavioural reference state
  int  m_cnt = 16'hFFFF, m_cap = 0, m_pc = 0;
  bit  m_s1, m_s2, m_s3, m_restart, m_ce, m_he, m_ue;

  always #2.5 clk = ~clk;

  tach_capture_channel uut (
    .clk(clk), .rst_n(rst_n), .tach_pri_i(tach_pri), .tach_alt_i(tach_alt),
    .tach_sel_i(tach_sel), .edge_sel_i(edge_sel), .chan_en_i(chan_en),
    .mode5_en_i(mode5_en), .clk_en_i(clk_en), .prescale_i(prescale),
    .cmp_val_i(cmp_val), .cmp_cfg_i(cmp_cfg), .count_o(count_o),
    .capture_o(capture_o), .cap_evt_o(cap_evt), .hit_evt_o(hit_evt),
    .udf_evt_o(udf_evt)
  );

  task automatic check(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 16'hFFFF; m_cap = 0; m_pc = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_restart = 0;
      m_ce = 0; m_he = 0; m_ue = 0;
    end else begin
      bit act, tk, edg, raw;
      act = mode5_en && chan_en;
      tk  = act && clk_en && (m_pc == int'(prescale));
      edg = edge_sel ? (!m_s2 && m_s3) : (m_s2 && !m_s3);
      raw = tach_sel ? tach_alt : tach_pri;
      if (!act) m_pc = 0;
      else if (clk_en) m_pc = tk ? 0 : (m_pc + 1) % 256;
      m_ce = 0; m_he = 0; m_ue = 0;
      if (!act || m_restart) begin
        m_cnt = 16'hFFFF; m_restart = 0;
      end else if (edg) begin
        m_cap = m_cnt; m_cnt = 16'hFFFF; m_ce = 1;
      end else if (tk) begin
        if (cmp_cfg[3]) begin m_cnt = 16'hFFFF; m_he = 1; m_restart = 1; end
        else if (m_cnt == 0) begin m_cnt = 16'hFFFF; m_ue = 1; end
        else if (cmp_cfg[2] && m_cnt - 1 <= int'(cmp_val)) begin
          m_cnt = cmp_val; m_he = 1; m_restart = 1;
        end else if (cmp_cfg[1] && cmp_val != 0 && m_cnt - 1 < int'(cmp_val)) begin
          m_cnt = int'(cmp_val) - 1; m_he = 1; m_restart = 1;
        end else m_cnt = m_cnt - 1;
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = raw;
    end
  end

  always @(negedge clk) if (rst_n) begin
    check(cur_tag, "count", count_o, m_cnt);
    check(cur_tag, "capture", capture_o, m_cap);
    check(cur_tag, "cap_evt", cap_evt, m_ce);
    check(cur_tag, "hit_evt", hit_evt, m_he);
    check(cur_tag, "udf_evt", udf_evt, m_ue);
    check("R14", "strobe count", int'(cap_evt) + int'(hit_evt) + int'(udf_evt) > 1, 0);
    n_cap += cap_evt; n_hit += hit_evt; n_udf += udf_evt;
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic idle();
    chan_en = 0; tach_pri = 0; tach_alt = 0; tach_sel = 0; edge_sel = 0;
    step(4);
  endtask

  task automatic go(logic [7:0] pre, logic [3:0] cfg, logic [15:0] cv);
    prescale = pre; cmp_cfg = cfg; cmp_val = cv;
    mode5_en = 1; chan_en = 1; clk_en = 1;
    n_cap = 0; n_hit = 0; n_udf = 0;
  endtask

  task automatic run_tach(int half, int cycles, bit use_alt);
    for (int i = 0; i < cycles; i++) begin
      if (i % half == 0) begin
        if (use_alt) tach_alt = ~tach_alt; else tach_pri = ~tach_pri;
      end
      step(1);
    end
  endtask

  initial begin
    #(190000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int saved;
    step(5);
    rst_n = 1;
    step(1);
    cur_tag = "R1";
    check("R1", "reset count", count_o, 16'hFFFF);
    check("R1", "reset capture", capture_o, 0);
    check("R1", "reset strobes", {cap_evt, hit_evt, udf_evt}, 0);

    cur_tag = "R3";
    mode5_en = 1; chan_en = 0; clk_en = 1; n_cap = 0;
    run_tach(3, 60, 0);
    mode5_en = 0; chan_en = 1;
    run_tach(3, 60, 0);
    settle();
    check("R3", "captures while inactive", n_cap, 0);
    check("R3", "count while inactive", count_o, 16'hFFFF);

    cur_tag = "R2";
    idle(); go(8'd3, 4'h0, 16'h0);
    step(40);
    check("R2", "count after 10 ticks", count_o, 16'hFFF5);
    clk_en = 0; step(20);
    check("R2", "count held without clock enable", count_o, 16'hFFF5);
    prescale = 0; clk_en = 1; step(20);
    check("R2", "count at prescale 0", count_o, 16'hFFE1);

    cur_tag = "R6";
    idle(); go(8'd1, 4'h0, 16'h0);
    run_tach(50, 600, 0); settle();
    check("R6", "rising captures", n_cap, 6);

    cur_tag = "R5";
    idle(); edge_sel = 1; go(8'd1, 4'h0, 16'h0);
    run_tach(50, 600, 0); settle();
    check("R5", "falling captures", n_cap, 6);

    cur_tag = "R4";
    idle(); tach_sel = 1; go(8'd0, 4'h0, 16'h0);
    run_tach(50, 300, 0); settle();
    check("R4", "deselected input ignored", n_cap, 0);
    n_cap = 0;
    run_tach(50, 300, 1); settle();
    check("R4", "alternate captures", n_cap, 3);

    cur_tag = "R8";
    idle(); go(8'd0, 4'h8, 16'h0);
    step(20); settle();
    check("R8", "immediate hits", n_hit, 10);

    cur_tag = "R9";
    idle(); go(8'd0, 4'h4, 16'hFFF0);
    step(15);
    check("R9", "equal stop value", count_o, 16'hFFF0);
    step(1);
    check("R12", "restart reload", count_o, 16'hFFFF);
    step(40);

    cur_tag = "R10";
    idle(); go(8'd0, 4'h2, 16'hFFF0);
    step(16);
    check("R10", "below stop value", count_o, 16'hFFEF);
    idle(); go(8'd0, 4'h2, 16'h0);
    step(200); settle();
    check("R10", "zero target no hit", n_hit, 0);
    check("R10", "zero target count", count_o, 16'hFF37);

    cur_tag = "R11";
    idle(); go(8'd0, 4'hE, 16'hFFF0);
    step(1); settle();
    check("R11", "high wins hit", n_hit, 1);
    check("R11", "high wins count", count_o, 16'hFFFF);
    idle(); go(8'd0, 4'h6, 16'hFFF0);
    step(15);
    check("R11", "equal over below", count_o, 16'hFFF0);
    idle(); go(8'd0, 4'h0, 16'h0);
    run_tach(7, 200, 0);

    cur_tag = "R12";
    idle(); go(8'd0, 4'h4, 16'hFFFA);
    run_tach(4, 400, 0); settle();
    check("R12", "hits happened", n_hit > 0, 1);

    cur_tag = "R13";
    idle(); go(8'd0, 4'h1, 16'h0);
    run_tach(20, 200, 0); settle();
    check("R13", "select bit no hit", n_hit, 0);
    check("R13", "select bit captures", n_cap, 5);

    cur_tag = "R7";
    idle(); saved = capture_o; go(8'd0, 4'h0, 16'h0);
    step(65600); settle();
    check("R7", "underflow count", n_udf, 1);
    check("R7", "capture unchanged", capture_o, saved);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule